// File: doc/BRIEF.md
# Power-Down Sequencer with Wake-Up Interrupt Routing

This block handles a chip's move into its low-power state and its way back out. Software sets a request bit in a small control register. After a fixed delay the block drops the enable that keeps the fast oscillator and the PLL running. While that request stands, a force output holds every local power-saving control in its low-power setting.

A second register decides how interrupt sources are routed. In normal routing, keypad and card events go to their own interrupt lines and the user pins drive line 0 directly. In wake routing, all three sources are gathered into one wake request. An event in wake routing ends power-down at once. Line 0 is then raised only after a long settling delay, which gives the analog circuits and the clocks time to stabilise. Reading the routing register clears the wake-routing bit and also acknowledges the pending wake interrupt.

The bus is a simple one-cycle strobe interface. Read data is combinational while the read strobe is high. Register updates take effect at the clock edge that samples the strobe.

Top module: `pwr_wake_ctl`

## Requirements
- R1: After reset both registers read 0x00, `ana_en` is 1, and `pwr_save_force`, `uart_lpbk`, `ser_sel`, `irq0`, `irq4` and `irq5` are 0.
- R2: The routing register is at address 0xFF94 and the power register at 0xFFF1. Routing fields: bit 7 wake routing, bit 1 keypad enable, bit 0 keypad flag. Power fields: bit 7 power-down request, bit 1 loopback (drives `uart_lpbk`), bit 0 pin select (drives `ser_sel`). Bits 6..2 read 0 and ignore writes. Any other address reads 0x00.
- R3: A read of the routing register returns its current value. The same edge clears bit 7 to 0.
- R4: The keypad flag sets on `kp_evt` whatever the enable bit holds. Writing 0 to bit 0 clears the flag, and writing 1 leaves it unchanged. `irq5` is the flag ANDed with the enable while wake routing is off.
- R5: While wake routing is off, `irq0` is the OR of `usr_evt` with no delay, and `irq4` follows `sc_evt`.
- R6: While wake routing is on, `irq4` and `irq5` stay 0 and the user pins have no direct path to `irq0`.
- R7: `ana_en` falls exactly 32 clocks after the edge that writes the power-down request to 1. `pwr_save_force` equals the request bit.
- R8: When the request is written back to 0, the shutdown is cancelled if it is still pending, or `ana_en` is restored if it has already dropped. Either way `ana_en` is 1 whenever the request is 0.
- R9: With wake routing on, an event on `kp_evt`, `sc_evt` or any `usr_evt` pin raises `irq0` exactly 512 clocks after the edge that samples it. Further events during the count do not restart it. `irq0` stays high until the routing register is read.
- R10: A wake-routed event while power-down is requested clears the request bit and sets `ana_en` to 1 at the next edge.
- R11: With wake routing off, events do not end power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 16 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high |
| kp_evt | input | 1 | Keypad event |
| sc_evt | input | 1 | Smart-card event |
| usr_evt | input | 8 | User-pin events |
| ana_en | output | 1 | Fast oscillator and PLL enable |
| pwr_save_force | output | 1 | Forces local power-saving controls to low power |
| uart_lpbk | output | 1 | UART loopback select |
| ser_sel | output | 1 | Serial pin select |
| irq0 | output | 1 | Interrupt line 0 (direct user pins or delayed wake) |
| irq4 | output | 1 | Card interrupt |
| irq5 | output | 1 | Keypad interrupt |

## Verification
The hardest case to reach is a wake that arrives after the analog enable has already dropped. Reaching it takes three steps: wake routing must be armed, the power-down request written, and more than 32 clocks allowed to pass. Only then can a single keypad pulse be applied. The stimulus does exactly this and counts clocks from the sampling edge. It checks that the enable returns on the next edge and that line 0 is still low one clock before the 512th edge and high just after it. A second event injected mid-count shows that the count is not restarted.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;

   typedef struct packed {
      logic redir;
      logic kp_ie;
      logic kp_flag;
   } route_reg_t;

   typedef struct packed {
      logic pd;
      logic lpbk;
      logic ssel;
   } power_reg_t;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/pwr_delay_timer.sv
module pwr_delay_timer #(
   parameter int unsigned DELAY = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   output logic expire
);
   localparam int unsigned CW = pwr_wake_pkg::cnt_width(DELAY);
   localparam logic [CW-1:0] LIMIT = CW'(DELAY - 1);

   logic [CW-1:0] cnt_q;

   assign expire = en && (cnt_q == LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (clr)             cnt_q <= '0;
      else if (en && !expire)   cnt_q <= cnt_q + CW'(1);
   end
endmodule

// File: rtl/pwr_wake_regs.sv
module pwr_wake_regs
   import pwr_wake_pkg::*;
#(
   parameter int unsigned      ADDR_W      = 16,
   parameter logic [ADDR_W-1:0] ROUTE_ADDR = 16'hFF94,
   parameter logic [ADDR_W-1:0] POWER_ADDR = 16'hFFF1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              rd,
   input  logic [7:0]        wdata,
   input  logic              kp_evt,
   input  logic              wake_req,
   output route_reg_t        route_q,
   output power_reg_t        power_q,
   output logic [7:0]        rdata,
   output logic              route_rd,
   output logic              pd_drop
);
   logic sel_route, sel_power, wake_exit, unused_wbits;

   assign sel_route    = (addr == ROUTE_ADDR);
   assign sel_power    = (addr == POWER_ADDR);
   assign route_rd     = rd && !wr && sel_route;
   assign wake_exit    = wake_req && power_q.pd;
   assign pd_drop      = power_q.pd && (wake_exit || (wr && sel_power && !wdata[7]));
   assign unused_wbits = ^wdata[6:2];

   always_comb begin
      rdata = 8'h00;
      if (rd && sel_route)
         rdata = {route_q.redir, 5'b0, route_q.kp_ie, route_q.kp_flag};
      else if (rd && sel_power)
         rdata = {power_q.pd, 5'b0, power_q.lpbk, power_q.ssel};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         route_q <= '0;
      end else begin
         if (wr && sel_route) begin
            route_q.redir <= wdata[7];
            route_q.kp_ie <= wdata[1];
         end else if (route_rd) begin
            route_q.redir <= 1'b0;
         end
         if (kp_evt)
            route_q.kp_flag <= 1'b1;
         else if (wr && sel_route && !wdata[0])
            route_q.kp_flag <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         power_q <= '0;
      end else begin
         if (wake_exit)
            power_q.pd <= 1'b0;
         else if (wr && sel_power)
            power_q.pd <= wdata[7];
         if (wr && sel_power) begin
            power_q.lpbk <= wdata[1];
            power_q.ssel <= wdata[0];
         end
      end
   end
endmodule

// File: rtl/pwr_wake_route.sv
module pwr_wake_route #(
   parameter int unsigned USR_W = 8
) (
   input  logic             redir,
   input  logic             kp_ie,
   input  logic             kp_flag,
   input  logic             kp_evt,
   input  logic             sc_evt,
   input  logic [USR_W-1:0] usr_evt,
   input  logic             wake_pend,
   output logic             wake_req,
   output logic             irq0,
   output logic             irq4,
   output logic             irq5
);
   logic [USR_W:0] usr_or;

   assign usr_or[0] = 1'b0;
   for (genvar i = 0; i < USR_W; i++) begin : g_usr
      assign usr_or[i+1] = usr_or[i] | usr_evt[i];
   end

   assign wake_req = redir && (kp_evt || sc_evt || usr_or[USR_W]);
   assign irq0     = wake_pend || (!redir && usr_or[USR_W]);
   assign irq4     = !redir && sc_evt;
   assign irq5     = !redir && kp_ie && kp_flag;
endmodule

// File: rtl/pwr_wake_ctl.sv
module pwr_wake_ctl
   import pwr_wake_pkg::*;
#(
   parameter int unsigned       ADDR_W      = 16,
   parameter int unsigned       USR_W       = 8,
   parameter int unsigned       PD_DELAY    = 32,
   parameter int unsigned       WAKE_DELAY  = 512,
   parameter logic [ADDR_W-1:0] ROUTE_ADDR  = 16'hFF94,
   parameter logic [ADDR_W-1:0] POWER_ADDR  = 16'hFFF1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              kp_evt,
   input  logic              sc_evt,
   input  logic [USR_W-1:0]  usr_evt,
   output logic              ana_en,
   output logic              pwr_save_force,
   output logic              uart_lpbk,
   output logic              ser_sel,
   output logic              irq0,
   output logic              irq4,
   output logic              irq5
);
   if (PD_DELAY < 2) begin : g_bad_pd
      $error("PD_DELAY must be at least 2");
   end
   if (WAKE_DELAY <= PD_DELAY) begin : g_bad_wake
      $error("WAKE_DELAY must exceed PD_DELAY");
   end
   if (USR_W < 1) begin : g_bad_usr
      $error("USR_W must be at least 1");
   end
   if (ROUTE_ADDR == POWER_ADDR) begin : g_bad_addr
      $error("register addresses must differ");
   end

   route_reg_t route_q;
   power_reg_t power_q;
   logic route_rd, pd_drop, wake_req, redir_on;
   logic ana_off_q, pd_expire, wk_busy_q, wk_expire, wake_pend_q;

   pwr_wake_regs #(
      .ADDR_W(ADDR_W), .ROUTE_ADDR(ROUTE_ADDR), .POWER_ADDR(POWER_ADDR)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
      .wdata(bus_wdata), .kp_evt(kp_evt), .wake_req(wake_req),
      .route_q(route_q), .power_q(power_q), .rdata(bus_rdata),
      .route_rd(route_rd), .pd_drop(pd_drop)
   );

   assign redir_on = route_q.redir;

   pwr_wake_route #(.USR_W(USR_W)) u_route (
      .redir(redir_on), .kp_ie(route_q.kp_ie), .kp_flag(route_q.kp_flag),
      .kp_evt(kp_evt), .sc_evt(sc_evt), .usr_evt(usr_evt),
      .wake_pend(wake_pend_q), .wake_req(wake_req),
      .irq0(irq0), .irq4(irq4), .irq5(irq5)
   );

   pwr_delay_timer #(.DELAY(PD_DELAY)) u_pd_tmr (
      .clk(clk), .rst_n(rst_n), .clr(!power_q.pd),
      .en(power_q.pd && !ana_off_q), .expire(pd_expire)
   );

   pwr_delay_timer #(.DELAY(WAKE_DELAY)) u_wk_tmr (
      .clk(clk), .rst_n(rst_n), .clr(!wk_busy_q),
      .en(wk_busy_q), .expire(wk_expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ana_off_q   <= 1'b0;
         wk_busy_q   <= 1'b0;
         wake_pend_q <= 1'b0;
      end else begin
         if (!power_q.pd || pd_drop) ana_off_q <= 1'b0;
         else if (pd_expire)         ana_off_q <= 1'b1;

         if (wk_expire)                   wk_busy_q <= 1'b0;
         else if (wake_req && !wk_busy_q) wk_busy_q <= 1'b1;

         if (wk_expire)     wake_pend_q <= 1'b1;
         else if (route_rd) wake_pend_q <= 1'b0;
      end
   end

   assign ana_en         = !ana_off_q;
   assign pwr_save_force = power_q.pd;
   assign uart_lpbk      = power_q.lpbk;
   assign ser_sel        = power_q.ssel;
endmodule

// File: rtl/pwr_wake_chk.sv
module pwr_wake_chk #(
   parameter int unsigned       ADDR_W     = 16,
   parameter int unsigned       USR_W      = 8,
   parameter int unsigned       PD_DELAY   = 32,
   parameter logic [ADDR_W-1:0] ROUTE_ADDR = 16'hFF94
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [USR_W-1:0]  usr_evt,
   input logic              ana_en,
   input logic              pwr_save_force,
   input logic              irq0,
   input logic              irq4,
   input logic              irq5,
   input logic              redir,
   input logic              wake_req
);
   int unsigned pd_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  pd_run <= 0;
      else if (!pwr_save_force)    pd_run <= 0;
      else if (pd_run != PD_DELAY) pd_run <= pd_run + 1;
   end

   AST_PD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_save_force |-> (ana_en == (pd_run < PD_DELAY))); // R7
   AST_ANA_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ana_en) |-> pwr_save_force); // R7
   AST_ANA_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_save_force |-> ana_en); // R8
   AST_REDIR_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      redir |-> (!irq4 && !irq5)); // R6
   AST_DIRECT_PINS: assert property (@(posedge clk) disable iff (!rst_n)
      (!redir && (|usr_evt)) |-> irq0); // R5
   AST_WAKE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_req && pwr_save_force) |=> (!pwr_save_force && ana_en)); // R10
   AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_wr && bus_addr == ROUTE_ADDR) |=> !redir); // R3
endmodule

bind pwr_wake_ctl pwr_wake_chk #(
   .ADDR_W(ADDR_W), .USR_W(USR_W), .PD_DELAY(PD_DELAY), .ROUTE_ADDR(ROUTE_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
   .usr_evt(usr_evt), .ana_en(ana_en), .pwr_save_force(pwr_save_force),
   .irq0(irq0), .irq4(irq4), .irq5(irq5), .redir(redir_on), .wake_req(wake_req)
);

// File: tb/sim_pwr_wake_ctl.sv
module sim_pwr_wake_ctl;
   localparam logic [15:0] RA = 16'hFF94;
   localparam logic [15:0] PA = 16'hFFF1;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [15:0] bus_addr = '0;
   logic bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0, bus_rdata;
   logic kp_evt = 1'b0, sc_evt = 1'b0;
   logic [7:0] usr_evt = '0;
   logic ana_en, pwr_save_force, uart_lpbk, ser_sel, irq0, irq4, irq5;
   int n_chk = 0, n_fail = 0;
   logic [7:0] rd;

   always #4 clk = ~clk;

   pwr_wake_ctl u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .kp_evt(kp_evt), .sc_evt(sc_evt),
      .usr_evt(usr_evt), .ana_en(ana_en), .pwr_save_force(pwr_save_force),
      .uart_lpbk(uart_lpbk), .ser_sel(ser_sel), .irq0(irq0), .irq4(irq4), .irq5(irq5)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [15:0] a, output logic [7:0] d);
      @(negedge clk); bus_addr = a; bus_rd = 1'b1;
      #2 d = bus_rdata;
      @(negedge clk); bus_rd = 1'b0;
   endtask

   task automatic pulse_kp();
      @(negedge clk); kp_evt = 1'b1;
      @(negedge clk); kp_evt = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #(8 * 150000);
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      check("R1 ana_en", ana_en, 1);
      check("R1 force", pwr_save_force, 0);
      check("R1 irqs", {irq0, irq4, irq5}, 0);
      check("R1 misc outs", {uart_lpbk, ser_sel}, 0);
      rd_reg(RA, rd); check("R1 route reg", rd, 8'h00);
      rd_reg(PA, rd); check("R1 power reg", rd, 8'h00);

      // R2 sweep power register
      for (int v = 0; v < 256; v++) begin
         wr_reg(PA, 8'(v));
         rd_reg(PA, rd);
         check("R2 power readback", rd, 8'(v) & 8'h83);
         check("R2 lpbk/ssel", {uart_lpbk, ser_sel}, {1'(v >> 1), 1'(v)});
      end
      wr_reg(PA, 8'h00);
      rd_reg(16'hFF95, rd); check("R2 unmapped", rd, 8'h00);

      // R2/R3 sweep routing register
      for (int v = 0; v < 256; v++) begin
         wr_reg(RA, 8'(v));
         rd_reg(RA, rd);
         check("R2 route readback", rd, 8'(v) & 8'h82);
         rd_reg(RA, rd);
         check("R3 read clears redirect", rd, 8'(v) & 8'h02);
      end
      wr_reg(RA, 8'h00);

      // R5 direct routing sweep
      for (int v = 0; v < 256; v++) begin
         @(negedge clk); usr_evt = 8'(v); sc_evt = v[0];
         #1;
         check("R5 irq0 direct", irq0, (v != 0));
         check("R5 irq4 direct", irq4, v[0]);
      end
      @(negedge clk); usr_evt = '0; sc_evt = 1'b0;

      // R4 keypad flag and enable
      pulse_kp();
      check("R4 flag no enable irq5", irq5, 0);
      rd_reg(RA, rd); check("R4 flag set", rd, 8'h01);
      wr_reg(RA, 8'h03); check("R4 enabled irq5", irq5, 1);
      wr_reg(RA, 8'h02); check("R4 clear by 0", irq5, 0);
      wr_reg(RA, 8'h03);
      rd_reg(RA, rd); check("R4 write 1 no set", rd, 8'h02);
      pulse_kp(); check("R4 event raises irq5", irq5, 1);

      // R6 redirect masks, arms the wake timer
      wr_reg(RA, 8'h83);
      check("R6 irq5 masked", irq5, 0);
      @(negedge clk); sc_evt = 1'b1; usr_evt = 8'h10;
      #1;
      check("R6 irq4 masked", irq4, 0);
      check("R6 no direct irq0", irq0, 0);
      @(negedge clk); sc_evt = 1'b0; usr_evt = '0;
      idle(600);
      check("R9 wake pending", irq0, 1);
      rd_reg(RA, rd); check("R3 read before clear", rd, 8'h83);
      check("R9 ack by read", irq0, 0);
      wr_reg(RA, 8'h00);

      // R7 power-down timing
      wr_reg(PA, 8'h80);
      check("R7 force", pwr_save_force, 1);
      for (int m = 1; m <= 32; m++) begin
         @(negedge clk);
         if (m == 31) check("R7 ana_en before 32", ana_en, 1);
         if (m == 32) check("R7 ana_en at 32", ana_en, 0);
      end
      wr_reg(PA, 8'h00);
      check("R8 restore after drop", ana_en, 1);

      // R8 cancel
      wr_reg(PA, 8'h80);
      idle(10);
      wr_reg(PA, 8'h00);
      idle(40);
      check("R8 cancel ana_en", ana_en, 1);
      check("R8 cancel force", pwr_save_force, 0);

      // R9/R10 wake from power-down
      wr_reg(RA, 8'h80);
      wr_reg(PA, 8'h80);
      idle(40);
      check("R10 asleep", ana_en, 0);
      pulse_kp();
      check("R10 request cleared", pwr_save_force, 0);
      check("R10 ana_en back", ana_en, 1);
      for (int m = 1; m <= 512; m++) begin
         @(negedge clk);
         usr_evt = (m == 100) ? 8'h01 : 8'h00;
         if (m == 511) check("R9 irq0 before 512", irq0, 0);
         if (m == 512) check("R9 irq0 at 512", irq0, 1);
      end
      rd_reg(RA, rd); check("R9 route read", rd, 8'h81);
      check("R9 irq0 acked", irq0, 0);
      rd_reg(RA, rd); check("R3 redirect cleared", rd, 8'h01);

      // R11 unarmed event does not wake
      wr_reg(RA, 8'h00);
      wr_reg(PA, 8'h80);
      idle(40);
      pulse_kp();
      @(negedge clk); usr_evt = 8'hFF;
      @(negedge clk); usr_evt = 8'h00;
      idle(2);
      check("R11 still requested", pwr_save_force, 1);
      check("R11 still off", ana_en, 0);
      wr_reg(PA, 8'h00);
      check("R8 ana_en on exit", ana_en, 1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule